// File: doc/BRIEF.md
# Programmable square-wave counter/timer

This block is a 16-bit down-counting timer that turns one of several clock-enable sources into a symmetrical square wave. The wave is suitable as an oversampled baud clock for a serial port. The divisor is assembled from two 8-bit preset registers. Software also writes a source-select field, issues start and stop strobes, and reads the live count back one byte at a time.

Every source is a one-cycle tick in the system clock domain. Each tick from the selected source counts one unit of the current half-period. At the end of a half-period the output toggles and the counter reloads from the preset as it stands at that moment. Writing a new preset while the timer runs therefore only changes the half-periods that follow.

Top module: `sqwave_ctr`

## Requirements
- R1: After a synchronous reset, `sq_o` is 0, `rd_data_o` is 0, the timer is idle, both preset bytes are 0 and the source select is 0.
- R2: Without a start strobe the timer stays idle: `sq_o` never changes, however many ticks arrive.
- R3: Register writes decode `wr_addr_i` as follows: 0 = preset low byte, 1 = preset high byte, 2 = source select (bits 2:0). The divisor D is {high,low}. The first toggle comes D selected ticks after the start strobe is registered, and then one toggle follows every D ticks.
- R4: A preset of 0 or 1 acts as a divisor of 2.
- R5: A preset written during a half-period does not change that half-period. Each reload at a toggle takes the preset current at that toggle.
- R6: Only the source whose index equals the select field advances the count. Ticks on all other sources are ignored.
- R7: A stop strobe freezes the count and holds `sq_o`. When start and stop arrive in the same cycle, stop wins and the count is not reloaded.
- R8: A start strobe always reloads the count from the preset, including a restart after a stop.
- R9: A read with `rd_hi_i`=1 returns the count's high byte in `rd_data_o` one cycle later and captures the low byte in a snapshot. A read with `rd_hi_i`=0 returns that snapshot, not the live low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick_i | input | 8 | One-cycle tick from each candidate source |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address (0 low preset, 1 high preset, 2 select) |
| wr_data_i | input | 8 | Write data |
| start_i | input | 1 | Start strobe: reload the count and run |
| stop_i | input | 1 | Stop strobe: freeze the count and the output |
| rd_en_i | input | 1 | Read strobe |
| rd_hi_i | input | 1 | Read the high byte (1) or the low snapshot (0) |
| rd_data_o | output | 8 | Registered read data |
| sq_o | output | 1 | Square-wave output |

## Verification
Divisors of 6 and 0x0105 with a tick every cycle check the toggle spacing and the byte order of the two presets. Presets of 0 and 1 check the clamp to 2. A preset lowered in mid half-period shows whether the reload happens at the toggle or at once. A selected source held silent while a different source ticks separates the select logic from the count. After a stop, readback of a frozen count against a computed value shows that stop freezes, that stop outranks a simultaneous start, and that a restart reloads. A high-byte read on a running count followed by a delayed low-byte read shows the snapshot against the live value.

// File: rtl/sqwave_pkg.sv
package sqwave_pkg;
  typedef enum logic [1:0] {
    REG_PRE_LO = 2'd0,
    REG_PRE_HI = 2'd1,
    REG_SRCSEL = 2'd2
  } reg_addr_e;
endpackage

// File: rtl/sqwave_cfg.sv
module sqwave_cfg
  import sqwave_pkg::*;
#(
  parameter int BW   = 8,
  parameter int SELW = 3,
  localparam int CW  = 2 * BW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [BW-1:0]   wr_data,
  output logic [CW-1:0]   div,
  output logic [SELW-1:0] sel
);
  logic [BW-1:0] pre_lo_q, pre_hi_q;
  logic [CW-1:0] preset;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_lo_q <= '0;
      pre_hi_q <= '0;
      sel      <= '0;
    end else if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        REG_PRE_LO: pre_lo_q <= wr_data;
        REG_PRE_HI: pre_hi_q <= wr_data;
        REG_SRCSEL: sel      <= wr_data[SELW-1:0];
        default: ;
      endcase
    end
  end

  assign preset = {pre_hi_q, pre_lo_q};
  // smallest legal divisor is 2
  assign div = (preset < CW'(2)) ? CW'(2) : preset;

  p_div_min_r4: assert property (@(posedge clk) disable iff (rst) div >= CW'(2));
endmodule

// File: rtl/sqwave_tick_sel.sv
module sqwave_tick_sel #(
  parameter int NSRC = 8,
  localparam int SELW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] src,
  input  logic [SELW-1:0] sel,
  output logic            tick
);
  generate
    if (NSRC == 1) begin : g_single
      logic unused_sel;
      assign unused_sel = ^sel;
      assign tick = src[0];
    end else begin : g_mux
      assign tick = src[sel];
    end
  endgenerate
endmodule

// File: rtl/sqwave_core.sv
module sqwave_core #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          stop,
  input  logic          tick,
  input  logic [CW-1:0] div,
  output logic [CW-1:0] cnt,
  output logic          sq
);
  logic run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      run_q <= 1'b0;
      sq    <= 1'b0;
    end else if (stop) begin
      run_q <= 1'b0;
    end else if (start) begin
      run_q <= 1'b1;
      cnt   <= div;
    end else if (run_q && tick) begin
      if (cnt <= CW'(1)) begin
        sq  <= ~sq;
        cnt <= div;
      end else begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> $stable(sq));
  p_run_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    run_q |-> cnt != '0);
  p_stop_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    stop |=> (!run_q && $stable(cnt) && $stable(sq)));
  p_start_load_r8: assert property (@(posedge clk) disable iff (rst)
    (start && !stop) |=> (run_q && cnt == $past(div)));
  p_end_toggle_r5: assert property (@(posedge clk) disable iff (rst)
    (run_q && tick && !start && !stop && cnt == CW'(1)) |=> (sq != $past(sq) && cnt == $past(div)));
  p_no_tick_r6: assert property (@(posedge clk) disable iff (rst)
    (!tick && !start && !stop) |=> ($stable(cnt) && $stable(sq)));
endmodule

// File: rtl/sqwave_rdback.sv
module sqwave_rdback #(
  parameter int BW = 8,
  localparam int CW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          rd_hi,
  input  logic [CW-1:0] cnt,
  output logic [BW-1:0] rd_data
);
  logic [BW-1:0] lo_snap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_snap_q <= '0;
      rd_data   <= '0;
    end else if (rd_en) begin
      if (rd_hi) begin
        rd_data   <= cnt[CW-1:BW];
        lo_snap_q <= cnt[BW-1:0];
      end else begin
        rd_data   <= lo_snap_q;
      end
    end
  end

  p_hi_read_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_hi) |=> rd_data == $past(cnt[CW-1:BW]));
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/sqwave_ctr.sv
module sqwave_ctr #(
  parameter int BW   = 8,
  parameter int NSRC = 8,
  localparam int CW  = 2 * BW,
  localparam int SELW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_tick_i,
  input  logic            wr_en_i,
  input  logic [1:0]      wr_addr_i,
  input  logic [BW-1:0]   wr_data_i,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic            rd_en_i,
  input  logic            rd_hi_i,
  output logic [BW-1:0]   rd_data_o,
  output logic            sq_o
);
  logic [CW-1:0]   div, cnt;
  logic [SELW-1:0] sel;
  logic            tick;

  sqwave_cfg #(.BW(BW), .SELW(SELW)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
    .wr_data(wr_data_i), .div(div), .sel(sel)
  );

  sqwave_tick_sel #(.NSRC(NSRC)) u_sel (
    .src(src_tick_i), .sel(sel), .tick(tick)
  );

  sqwave_core #(.CW(CW)) u_core (
    .clk(clk), .rst(rst), .start(start_i), .stop(stop_i), .tick(tick),
    .div(div), .cnt(cnt), .sq(sq_o)
  );

  sqwave_rdback #(.BW(BW)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en_i), .rd_hi(rd_hi_i),
    .cnt(cnt), .rd_data(rd_data_o)
  );
endmodule

// File: tb/sim_sqwave_ctr.sv
module sim_sqwave_ctr;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] src = 8'h00;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic       start = 1'b0, stop = 1'b0, rd_en = 1'b0, rd_hi = 1'b0;
  logic [7:0] rd_data;
  logic       sq;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int exp_q[$];
  bit mon_en = 1'b0;
  logic prev_sq = 1'b0;
  string cur_req = "R2";

  sqwave_ctr u0 (
    .clk(clk), .rst(rst), .src_tick_i(src), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .start_i(start), .stop_i(stop),
    .rd_en_i(rd_en), .rd_hi_i(rd_hi), .rd_data_o(rd_data), .sq_o(sq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: every output toggle must match the next expected edge
  always @(negedge clk) begin
    if (mon_en) begin
      if (sq !== prev_sq) begin
        if (exp_q.size() == 0) chk(1'b0, cur_req, cyc, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(cyc == e, cur_req, cyc, e);
        end
      end
      prev_sq = sq;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic hi, output logic [7:0] v);
    rd_en = 1'b1; rd_hi = hi;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic pulse_stop();
    stop = 1'b1; @(negedge clk); stop = 1'b0;
  endtask

  // driver: start, queue expected toggle edges, stop after the last one
  task automatic run_expect(input int d, input int n, input string req);
    int s, last;
    cur_req = req;
    s = cyc;
    start = 1'b1; @(negedge clk); start = 1'b0;
    for (int k = 1; k <= n; k++) exp_q.push_back(s + 1 + d * k);
    last = s + 1 + d * n;
    wait_until(last + 1);
    pulse_stop();
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    #(150000 * 20);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v, lvl;
    int s;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sq === 1'b0, "R1", sq, 0);
    chk(rd_data === 8'h00, "R1", rd_data, 0);
    prev_sq = sq; mon_en = 1'b1;

    // R2: all sources ticking, no start
    cur_req = "R2"; src = 8'hFF;
    repeat (30) @(negedge clk);
    chk(sq === 1'b0, "R2", sq, 0);

    // R3: divisor 6 then 0x0105 via selected source 3
    src = 8'h08;
    wr(2'd2, 8'd3);
    wr(2'd0, 8'd6); wr(2'd1, 8'd0);
    run_expect(6, 4, "R3");
    wr(2'd0, 8'h05); wr(2'd1, 8'h01);
    run_expect(261, 2, "R3");

    // R4: presets 0 and 1 behave as 2
    wr(2'd1, 8'd0); wr(2'd0, 8'd0);
    run_expect(2, 5, "R4");
    wr(2'd0, 8'd1);
    run_expect(2, 5, "R4");

    // R5: preset lowered from 8 to 3 mid half-period
    cur_req = "R5";
    wr(2'd0, 8'd8);
    s = cyc;
    start = 1'b1; @(negedge clk); start = 1'b0;
    exp_q.push_back(s + 9); exp_q.push_back(s + 12); exp_q.push_back(s + 15);
    wait_until(s + 4);
    wr(2'd0, 8'd3);
    wait_until(s + 16);
    pulse_stop();
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R5", exp_q.size(), 0);
    exp_q.delete();

    // R6: select 5 silent while source 3 ticks, then source 5 ticks
    cur_req = "R6";
    wr(2'd0, 8'd4); wr(2'd2, 8'd5);
    lvl = {7'd0, sq};
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (40) @(negedge clk);
    pulse_stop();
    chk(sq === lvl[0], "R6", sq, lvl[0]);
    src = 8'h20;
    run_expect(4, 3, "R6");

    // R7: preset 0x0123, stop after 9 decrements -> count 0x011A
    cur_req = "R7";
    wr(2'd1, 8'h01); wr(2'd0, 8'h23);
    s = cyc;
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_until(s + 10);
    pulse_stop();
    rd(1'b1, v); chk(v == 8'h01, "R7", v, 8'h01);
    rd(1'b0, v); chk(v == 8'h1A, "R7", v, 8'h1A);
    lvl = {7'd0, sq};
    repeat (20) @(negedge clk);
    rd(1'b1, v); chk(v == 8'h01, "R7", v, 8'h01);
    rd(1'b0, v); chk(v == 8'h1A, "R7", v, 8'h1A);
    chk(sq === lvl[0], "R7", sq, lvl[0]);
    start = 1'b1; stop = 1'b1; @(negedge clk); start = 1'b0; stop = 1'b0;
    repeat (300) @(negedge clk);
    rd(1'b1, v); chk(v == 8'h01, "R7", v, 8'h01);
    rd(1'b0, v); chk(v == 8'h1A, "R7", v, 8'h1A);

    // R8: restart reloads from the new preset, not the frozen count
    wr(2'd1, 8'd0); wr(2'd0, 8'd5);
    run_expect(5, 2, "R8");

    // R9: running count 0x0200, high read then delayed low read
    cur_req = "R9";
    wr(2'd1, 8'h02); wr(2'd0, 8'h00);
    s = cyc;
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_until(s + 4);
    rd(1'b1, v); chk(v == 8'h01, "R9", v, 8'h01);
    wait_until(s + 8);
    rd(1'b0, v); chk(v == 8'hFD, "R9", v, 8'hFD);
    pulse_stop();
    repeat (5) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule